// File: doc/BRIEF.md
# Multiplexed-Bus Register Interface for an SPI Master

This block attaches an SPI master's configuration and data registers to a byte-wide microcontroller bus on which address and data share one set of pins. The bus master presents the upper address byte on a dedicated port and the lower byte on the shared port. It qualifies the address with an active-low latch strobe while the program-store strobe stays high, and then moves data with active-low read or write strobes. All four strobes pass through a synchronizer into the system clock domain. A four-state cycle machine then latches the address, checks it against a parameterised base, and either captures write data or drives read data onto the shared port. It releases the port as soon as the read strobe returns high.

The register set holds the status byte, the control byte, the slave-select mask, the transmit byte and the receive byte. The shifter and serial clock generator sit outside this block. They receive the control fields, the slave-select mask and the transmit byte, and they report back through flag inputs: the byte was taken, a byte arrived, the transfer is done, the bus is busy, and a contention error occurred. From the flag state the block derives a pending interrupt, gated by the START level, and drives an active-low interrupt pin. It also drives separate transmit-empty and receive-full pins.

Top module: `mbus_spi_regs`

## Requirements
- R1: After reset the interrupt pin is high, the transmit-empty pin is high, the receive-full pin is low, the data port is not driven (`ad_oe`=0), all control outputs are 0, and the status byte reads 0x18 while `done_i` and `busy_i` are low.
- R2: A bus cycle is accepted only when the latch strobe is low with the program-store strobe high, `addr_hi` equals `BASE_HI`, and the high nibble of the latched low byte equals `REG_PAGE`. Any other cycle leaves every register unchanged and never drives the port.
- R3: During an accepted read, `ad_oe` is 1 and `ad_o` carries the addressed register while the read strobe is low. `ad_oe` returns to 0 once the strobe is high. Low-nibble offsets are 0x0 status, 0x4 control, 0x8 slave select, 0xA transmit and 0xE receive. Other offsets in the page read 0x00, and writes to them have no effect.
- R4: The control byte drives bit7 `spien_o`, bit6 the interrupt enable, bit5 `start_o`, bits4:3 `clkdiv_o`, bit2 `cpha_o`, bit1 `cpol_o` and bit0 `rcv_cpol_o`. The control, slave-select and transmit registers read back what was written. The slave-select byte appears on `ss_sel_o` and the transmit byte on `tx_data_o`.
- R5: A write to the transmit register clears `xmit_empty_o`. A `tx_load_i` pulse sets it again.
- R6: A `rx_valid_i` pulse loads `rx_data_i` into the receive register and sets `rcv_full_o`. A completed read of the receive register clears `rcv_full_o`.
- R7: An `err_i` pulse sets the sticky error bit, which is status bit6. A status write with bit6=0 clears it. A status write with bit6=1 leaves it set, and all other status bits ignore writes.
- R8: An interrupt is pending when transmit-empty and START=1, or receive-full and START=0, or the error bit is set. Status bit4 holds the inverse of pending.
- R9: `int_n_o` is low exactly when an interrupt is pending and the interrupt enable (control bit6) is 1.
- R10: Status bit7 follows `done_i`, bit5 follows `busy_i`, bit3 is transmit-empty, bit2 is receive-full, and bits 1:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| addr_hi | input | 8 | Upper address byte |
| ad_i | input | 8 | Shared address/data port, inbound |
| ad_o | output | 8 | Shared port, outbound read data |
| ad_oe | output | 1 | Drive enable for the shared port |
| ale_n | input | 1 | Address latch strobe, active low |
| psen_n | input | 1 | Program-store strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| done_i | input | 1 | Byte transfer finished flag from the shifter |
| busy_i | input | 1 | Slave select active flag from the shifter |
| err_i | input | 1 | Contention error pulse |
| tx_load_i | input | 1 | Shifter took the transmit byte |
| rx_valid_i | input | 1 | Received byte valid pulse |
| rx_data_i | input | 8 | Received byte |
| spien_o | output | 1 | SPI enable |
| start_o | output | 1 | Transfer start level |
| clkdiv_o | output | 2 | Serial clock divider select |
| cpha_o | output | 1 | Clock phase |
| cpol_o | output | 1 | Clock polarity |
| rcv_cpol_o | output | 1 | Receive sampling edge |
| ss_sel_o | output | 8 | Slave-select mask |
| tx_data_o | output | 8 | Transmit byte |
| int_n_o | output | 1 | Interrupt request, active low |
| xmit_empty_o | output | 1 | Transmit register empty |
| rcv_full_o | output | 1 | Receive register full |

## Verification
The bench runs cycles that must be rejected: a wrong upper byte, a wrong page nibble, and the program-store strobe held low. A design that decoded too loosely would corrupt control or drive the port onto another device's read. It reads the receive register and checks that receive-full falls only after the cycle. It also checks that a status write with bit6 set leaves the error bit set, which catches a decoder that clears the error on any status write. Random sequences of writes, flag pulses and reads are compared with a bench model of the START-gated pending term. An implementation that ignored START, or latched the interrupt instead of deriving it, would show a wrong status bit4 or interrupt pin.

// File: rtl/mbus_spi_regs.sv
module mbus_spi_regs #(
  parameter logic [7:0] BASE_HI     = 8'hC0,
  parameter logic [3:0] REG_PAGE    = 4'h8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] addr_hi,
  input  logic [7:0] ad_i,
  output logic [7:0] ad_o,
  output logic       ad_oe,
  input  logic       ale_n,
  input  logic       psen_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       done_i,
  input  logic       busy_i,
  input  logic       err_i,
  input  logic       tx_load_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  output logic       spien_o,
  output logic       start_o,
  output logic [1:0] clkdiv_o,
  output logic       cpha_o,
  output logic       cpol_o,
  output logic       rcv_cpol_o,
  output logic [7:0] ss_sel_o,
  output logic [7:0] tx_data_o,
  output logic       int_n_o,
  output logic       xmit_empty_o,
  output logic       rcv_full_o
);

  localparam logic [3:0] OFF_STAT = 4'h0;
  localparam logic [3:0] OFF_CTRL = 4'h4;
  localparam logic [3:0] OFF_SSEL = 4'h8;
  localparam logic [3:0] OFF_TX   = 4'hA;
  localparam logic [3:0] OFF_RX   = 4'hE;

  typedef enum logic [1:0] {S_IDLE, S_DECODE, S_XFER, S_END} cyc_t;

  cyc_t        state;
  logic [3:0]  sq [SYNC_STAGES];
  logic        ale_s, psen_s, rd_s, wr_s;
  logic [7:0]  hi_q, lo_q;
  logic        is_rd;
  logic [7:0]  ctrl_q, ssel_q, tx_q, rx_q;
  logic        xe_q, rf_q, err_q;
  logic [7:0]  rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) sq[i] <= 4'hF;
    end else begin
      sq[0] <= {ale_n, psen_n, rd_n, wr_n};
      for (int i = 1; i < SYNC_STAGES; i++) sq[i] <= sq[i-1];
    end
  end
  assign {ale_s, psen_s, rd_s, wr_s} = sq[SYNC_STAGES-1];

  wire [3:0] off     = lo_q[3:0];
  wire       hit     = (hi_q == BASE_HI) && (lo_q[7:4] == REG_PAGE);
  wire       go      = (state == S_DECODE) && hit && (!rd_s || !wr_s);
  wire       wr_fire = go && !wr_s && rd_s;
  wire       rd_done = (state == S_XFER) && is_rd && rd_s && wr_s;
  wire       rx_take = rd_done && (off == OFF_RX);
  wire       pend    = (xe_q && ctrl_q[5]) || (rf_q && !ctrl_q[5]) || err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      hi_q  <= '0;
      lo_q  <= '0;
      is_rd <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (!ale_s && psen_s) begin
          state <= S_DECODE;
          hi_q  <= addr_hi;
          lo_q  <= ad_i;
        end
        S_DECODE: begin
          if (go) begin
            state <= S_XFER;
            is_rd <= !rd_s;
          end else if (ale_s) begin
            state <= S_IDLE;
          end
        end
        S_XFER: if (rd_s && wr_s) state <= S_END;
        S_END:  if (ale_s) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ssel_q <= '0;
      tx_q   <= '0;
    end else if (wr_fire) begin
      case (off)
        OFF_CTRL: ctrl_q <= ad_i;
        OFF_SSEL: ssel_q <= ad_i;
        OFF_TX:   tx_q   <= ad_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xe_q  <= 1'b1;
      rf_q  <= 1'b0;
      err_q <= 1'b0;
      rx_q  <= '0;
    end else begin
      if (wr_fire && off == OFF_TX) xe_q <= 1'b0;
      else if (tx_load_i)           xe_q <= 1'b1;
      if (rx_valid_i) begin
        rf_q <= 1'b1;
        rx_q <= rx_data_i;
      end else if (rx_take) begin
        rf_q <= 1'b0;
      end
      if (err_i) err_q <= 1'b1;
      else if (wr_fire && off == OFF_STAT && !ad_i[6]) err_q <= 1'b0;
    end
  end

  always_comb begin
    case (off)
      OFF_STAT: rd_mux = {done_i, err_q, busy_i, !pend, xe_q, rf_q, 2'b00};
      OFF_CTRL: rd_mux = ctrl_q;
      OFF_SSEL: rd_mux = ssel_q;
      OFF_TX:   rd_mux = tx_q;
      OFF_RX:   rd_mux = rx_q;
      default:  rd_mux = 8'h00;
    endcase
  end

  assign ad_oe        = (state == S_XFER) && is_rd;
  assign ad_o         = ad_oe ? rd_mux : 8'h00;
  assign spien_o      = ctrl_q[7];
  assign start_o      = ctrl_q[5];
  assign clkdiv_o     = ctrl_q[4:3];
  assign cpha_o       = ctrl_q[2];
  assign cpol_o       = ctrl_q[1];
  assign rcv_cpol_o   = ctrl_q[0];
  assign ss_sel_o     = ssel_q;
  assign tx_data_o    = tx_q;
  assign xmit_empty_o = xe_q;
  assign rcv_full_o   = rf_q;
  assign int_n_o      = !(pend && ctrl_q[6]);

  p_drive_needs_hit_r3: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> hit);

  p_tx_write_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && off == OFF_TX) |=> !xmit_empty_o);

  p_rx_load_r6: assert property (@(posedge clk) disable iff (rst)
    rx_valid_i |=> (rcv_full_o && rx_q == $past(rx_data_i)));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(wr_fire && off == OFF_STAT)) |=> err_q);

  p_rx_irq_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_i && ctrl_q[6] && !ctrl_q[5] && !wr_fire) |=> !int_n_o);

endmodule

// File: tb/mbus_spi_regs_bench.sv
module mbus_spi_regs_bench;
  localparam logic [7:0] BH = 8'hC0;

  logic clk = 0, rst = 1;
  logic [7:0] addr_hi = 0, ad_i = 0, rx_data_i = 0;
  logic ale_n = 1, psen_n = 1, rd_n = 1, wr_n = 1;
  logic done_i = 0, busy_i = 0, err_i = 0, tx_load_i = 0, rx_valid_i = 0;
  logic [7:0] ad_o, ss_sel_o, tx_data_o;
  logic ad_oe, spien_o, start_o, cpha_o, cpol_o, rcv_cpol_o, int_n_o, xmit_empty_o, rcv_full_o;
  logic [1:0] clkdiv_o;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [7:0] m_ctrl = 0, m_ssel = 0, m_tx = 0, m_rx = 0;
  bit m_xe = 1, m_rf = 0, m_err = 0;

  always #2 clk = ~clk;

  mbus_spi_regs u_mbus_spi_regs (.*);

  function automatic bit pend_f();
    return (m_xe && m_ctrl[5]) || (m_rf && !m_ctrl[5]) || m_err;
  endfunction

  function automatic logic [7:0] exp_reg(logic [3:0] off);
    case (off)
      4'h0: return {done_i, m_err, busy_i, !pend_f(), m_xe, m_rf, 2'b00};
      4'h4: return m_ctrl;
      4'h8: return m_ssel;
      4'hA: return m_tx;
      4'hE: return m_rx;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] hi, logic [7:0] lo, logic [7:0] d, bit psen_low = 0);
    @(negedge clk); addr_hi = hi; ad_i = lo; psen_n = !psen_low; ale_n = 0;
    repeat (4) @(negedge clk); ad_i = d; wr_n = 0;
    repeat (5) @(negedge clk); wr_n = 1;
    repeat (4) @(negedge clk); ale_n = 1; psen_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_read(logic [7:0] hi, logic [7:0] lo, output logic [7:0] d,
                          output logic oe_mid, output logic oe_end);
    @(negedge clk); addr_hi = hi; ad_i = lo; ale_n = 0;
    repeat (4) @(negedge clk); ad_i = 8'h00; rd_n = 0;
    repeat (5) @(negedge clk); d = ad_o; oe_mid = ad_oe; rd_n = 1;
    repeat (4) @(negedge clk); oe_end = ad_oe; ale_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_chk(string req, logic [3:0] off);
    logic [7:0] d; logic om, oe;
    logic [7:0] e;
    e = exp_reg(off);
    bus_read(BH, {4'h8, off}, d, om, oe);
    chk(req, d, e);
    chk({req, " drive"}, {6'b0, om, oe}, 8'h02);
    if (off == 4'hE) m_rf = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0; @(negedge clk);
  endtask

  task automatic pins_chk(string req);
    chk(req, {5'b0, int_n_o, xmit_empty_o, rcv_full_o},
        {5'b0, !(pend_f() && m_ctrl[6]), m_xe, m_rf});
  endtask

  initial begin
    repeat (1500000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic om, oe;
    void'($urandom(32'd12345));
    repeat (4) @(negedge clk); rst = 0; @(negedge clk);

    // R1 reset state
    chk("R1 pins", {int_n_o, xmit_empty_o, rcv_full_o, ad_oe, spien_o, start_o, clkdiv_o},
        8'b1100_0000);
    read_chk("R1 status", 4'h0);
    chk("R1 status value", exp_reg(4'h0), 8'h18);

    // R4 control fields
    bus_write(BH, 8'h84, 8'b1011_0101); m_ctrl = 8'b1011_0101;
    chk("R4 fields", {spien_o, start_o, clkdiv_o, cpha_o, cpol_o, rcv_cpol_o, 1'b0},
        8'b1110_1010);
    read_chk("R4 ctrl readback", 4'h4);
    bus_write(BH, 8'h88, 8'h24); m_ssel = 8'h24;
    chk("R4 ss_sel", ss_sel_o, 8'h24);
    read_chk("R4 ssel readback", 4'h8);

    // R2 rejected cycles
    bus_write(8'hC1, 8'h84, 8'h00);
    bus_write(BH, 8'h94, 8'h00);
    bus_write(BH, 8'h84, 8'h00, 1);
    read_chk("R2 ctrl untouched", 4'h4);
    bus_read(8'h11, 8'h84, d, om, oe);
    chk("R2 no drive wrong hi", {7'b0, om}, 8'h00);
    bus_read(BH, 8'h74, d, om, oe);
    chk("R2 no drive wrong page", {7'b0, om}, 8'h00);

    // R3 unmapped offset
    bus_write(BH, 8'h82, 8'hFF);
    read_chk("R3 unmapped", 4'h2);
    read_chk("R3 ctrl after unmapped write", 4'h4);

    // R5 transmit empty
    bus_write(BH, 8'h8A, 8'h5A); m_tx = 8'h5A; m_xe = 0;
    chk("R5 tx_data", tx_data_o, 8'h5A);
    pins_chk("R5 xe cleared");
    pulse(tx_load_i); m_xe = 1;
    pins_chk("R5 xe set");

    // R6 receive
    rx_data_i = 8'hC3; pulse(rx_valid_i); m_rx = 8'hC3; m_rf = 1;
    pins_chk("R6 rf set");
    read_chk("R6 rx read", 4'hE);
    pins_chk("R6 rf cleared");

    // R7 error
    pulse(err_i); m_err = 1;
    read_chk("R7 err set", 4'h0);
    bus_write(BH, 8'h80, 8'hFF);
    read_chk("R7 write one keeps", 4'h0);
    bus_write(BH, 8'h80, 8'h00); m_err = 0;
    read_chk("R7 cleared", 4'h0);

    // R8 R9 interrupt gating
    bus_write(BH, 8'h84, 8'h60); m_ctrl = 8'h60;
    pins_chk("R9 tx empty with start");
    read_chk("R8 status pending", 4'h0);
    bus_write(BH, 8'h84, 8'h20); m_ctrl = 8'h20;
    pins_chk("R9 disabled");

    // R10 status mirrors inputs
    done_i = 1; busy_i = 1;
    read_chk("R10 done busy", 4'h0);
    done_i = 0; busy_i = 0;

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 8);
      done_i = $urandom_range(0, 1); busy_i = $urandom_range(0, 1);
      case (op)
        0: begin d = $urandom; bus_write(BH, 8'h84, d); m_ctrl = d; end
        1: begin d = $urandom; bus_write(BH, 8'h88, d); m_ssel = d; end
        2: begin d = $urandom; bus_write(BH, 8'h8A, d); m_tx = d; m_xe = 0; end
        3: begin d = $urandom; bus_write(BH, 8'h80, d); if (!d[6]) m_err = 0; end
        4: begin pulse(tx_load_i); m_xe = 1; end
        5: begin rx_data_i = $urandom; pulse(rx_valid_i); m_rx = rx_data_i; m_rf = 1; end
        6: begin if ($urandom_range(0, 3) == 0) begin pulse(err_i); m_err = 1; end end
        default: begin
          logic [3:0] offs [5] = '{4'h0, 4'h4, 4'h8, 4'hA, 4'hE};
          read_chk("R3 R8 R10 random read", offs[$urandom_range(0, 4)]);
        end
      endcase
      pins_chk("R8 R9 random pins");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule